// File: doc/BRIEF.md
# Supply-Fault Write Guard Sequencer

This block keeps a battery-backed byte memory safe while its main supply is unreliable. It runs from an always-on clock. It receives two comparator results that are already digital: one says the supply is above the level at which the memory must be deselected, and the other says the supply is above the lower level at which the memory's power source changes over. From these it decides when the memory is write-protected with its outputs disabled, and when the battery feeds the array. It also times the hold-off period after power comes back.

Both comparator flags pass through a two-flop synchronizer and a glitch filter before they are used. A four-state sequencer then walks through normal, protected, battery and recovering phases. Protection takes hold without delay on a falling supply, apart from an optional worst-case latency that software can program. On a rising supply, protection is released only after a fixed recovery count. A fault monitor on the memory's enable pins records two events. The first is a write that was in progress when protection struck, together with its address. The second is the chip enable being driven active during the recovery window.

Top module: `pfw_guard`

## Requirements
- R1: While reset is held, the state output reads PROTECT (code 1), write protect and output disable are 1, battery select is 0, and both sticky fault flags and the captured address are 0.
- R2: A comparator flag change takes effect only after the flag holds its new value for FILT_N consecutive cycles past a two-flop synchronizer. The state then moves FILT_N+3 clock edges after the raw input changes. A pulse shorter than FILT_N cycles has no effect on the state.
- R3: In NORMAL, a loss of the deselect flag moves the state to PROTECT lat_i cycles after the filtered flag drops (lat_i = 0 means the next edge), and it raises write protect and output disable.
- R4: A low switchover flag while protected moves the state to BATTERY (code 2) with battery select 1. When the flag returns high the battery is released, and the state goes to PROTECT if the deselect flag is still low. A low switchover flag in NORMAL moves the state to PROTECT with no programmed latency.
- R5: Once both filtered flags are high, the state passes through RECOVER (code 3) for exactly REC_N cycles with protection held, then reaches NORMAL (code 0). A loss of the deselect flag during RECOVER returns the state to PROTECT, and the next recovery starts again from zero.
- R6: The state never moves from BATTERY directly to NORMAL. NORMAL is entered only from RECOVER.
- R7: If chip enable and write enable (both active low) are both active on the edge where NORMAL turns into PROTECT, the sticky interrupted-write flag sets and the address pins are captured.
- R8: While the state is not NORMAL, write activity on the enable and address pins neither sets the interrupted-write flag nor changes the captured address.
- R9: Chip enable active during RECOVER sets a sticky violation flag one edge later. Chip enable active in NORMAL or PROTECT leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| desel_ok_i | input | 1 | Supply above deselect threshold (async) |
| swover_ok_i | input | 1 | Supply above battery switchover threshold (async) |
| ce_n_i | input | 1 | Memory chip enable, active low |
| we_n_i | input | 1 | Memory write enable, active low |
| addr_i | input | AW | Memory address |
| lat_i | input | LW | Programmed protection latency in cycles |
| state_o | output | 2 | Sequencer state code |
| wprot_o | output | 1 | Deselect / write protect |
| odis_o | output | 1 | Data output disable |
| bat_sel_o | output | 1 | Battery selected as array supply |
| intr_wr_o | output | 1 | Sticky interrupted-write flag |
| intr_addr_o | output | AW | Address of the interrupted write |
| ce_viol_o | output | 1 | Sticky chip-enable-during-recovery flag |

## Verification
The hardest case to reach is a supply dip that arrives in the middle of a recovery window. The filter delay and the recovery count race each other, so the dip must be timed to land before the count expires. The bench uses a recovery count longer than the full input-to-state delay. It drops the deselect flag a few cycles into RECOVER, and after the next power-up it checks the edge-exact length of a full recovery period. Precise edge counts also separate a pulse one cycle too short for the filter from one just long enough, and separate the programmed latency from the switchover path that bypasses it.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

    typedef enum logic [1:0] {
        PF_NORMAL  = 2'd0,
        PF_PROTECT = 2'd1,
        PF_BATTERY = 2'd2,
        PF_RECOVER = 2'd3
    } pf_state_e;

    localparam int PF_NUM_LVLS = 2;
    localparam int PF_LVL_DESEL = 0;
    localparam int PF_LVL_SWOVR = 1;

    typedef struct packed {
        logic above_swovr;
        logic above_desel;
    } pf_levels_t;

    function automatic logic pf_guarded(input pf_state_e s);
        return s != PF_NORMAL;
    endfunction

    function automatic logic pf_write_active(input logic ce_n, input logic we_n);
        return !ce_n && !we_n;
    endfunction

endpackage

// File: rtl/pfw_level_filter.sv
module pfw_level_filter #(
    parameter int FILT_N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int CW = $clog2(FILT_N + 1);

    logic          meta_q;
    logic          sync_q;
    logic          lvl_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            lvl_q  <= 1'b0;
            run_q  <= '0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            if (sync_q != lvl_q) begin
                if (run_q == CW'(FILT_N - 1)) begin
                    lvl_q <= sync_q;
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign lvl_o = lvl_q;

    assert_filter_source_R2: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(sync_q)));

    assert_filter_run_bound_R2: assert property (@(posedge clk) disable iff (rst)
        run_q < CW'(FILT_N));

endmodule

// File: rtl/pfw_seq.sv
module pfw_seq
    import pfw_pkg::*;
#(
    parameter int REC_N = 125000,
    parameter int LW    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  pf_levels_t lv_i,
    input  logic [LW-1:0] lat_i,
    output pf_state_e  state_o,
    output logic       enter_prot_o
);
    localparam int RCW = (REC_N > 1) ? $clog2(REC_N) : 1;

    pf_state_e      state_q, state_d;
    logic [RCW-1:0] rec_q, rec_d;
    logic [LW-1:0]  lat_q, lat_d;

    always_comb begin
        state_d = state_q;
        rec_d   = '0;
        lat_d   = '0;
        unique case (state_q)
            PF_NORMAL: begin
                if (!lv_i.above_swovr) begin
                    state_d = PF_PROTECT;
                end else if (!lv_i.above_desel) begin
                    if (lat_q >= lat_i) state_d = PF_PROTECT;
                    else                lat_d   = lat_q + 1'b1;
                end
            end
            PF_PROTECT: begin
                if (!lv_i.above_swovr)     state_d = PF_BATTERY;
                else if (lv_i.above_desel) state_d = PF_RECOVER;
            end
            PF_BATTERY: begin
                if (lv_i.above_swovr)
                    state_d = lv_i.above_desel ? PF_RECOVER : PF_PROTECT;
            end
            PF_RECOVER: begin
                if (!lv_i.above_swovr || !lv_i.above_desel) begin
                    state_d = PF_PROTECT;
                end else if (rec_q == RCW'(REC_N - 1)) begin
                    state_d = PF_NORMAL;
                end else begin
                    rec_d = rec_q + 1'b1;
                end
            end
            default: state_d = PF_PROTECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PF_PROTECT;
            rec_q   <= '0;
            lat_q   <= '0;
        end else begin
            state_q <= state_d;
            rec_q   <= rec_d;
            lat_q   <= lat_d;
        end
    end

    assign state_o      = state_q;
    assign enter_prot_o = (state_q == PF_NORMAL) && (state_d == PF_PROTECT);

    assert_no_battery_to_normal_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PF_NORMAL) |-> ($past(state_q) != PF_BATTERY));

    assert_normal_from_recover_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PF_NORMAL && $past(state_q) != PF_NORMAL) |-> ($past(state_q) == PF_RECOVER));

    assert_recover_count_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == PF_NORMAL && $past(state_q) == PF_RECOVER) |-> ($past(rec_q) == RCW'(REC_N - 1)));

    assert_battery_needs_low_swovr_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == PF_BATTERY && $past(state_q) != PF_BATTERY) |-> !$past(lv_i.above_swovr));

endmodule

// File: rtl/pfw_fault_log.sv
module pfw_fault_log
    import pfw_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  pf_state_e     state_i,
    input  logic          enter_prot_i,
    input  logic          ce_n_i,
    input  logic          we_n_i,
    input  logic [AW-1:0] addr_i,
    output logic          intr_wr_o,
    output logic [AW-1:0] intr_addr_o,
    output logic          ce_viol_o
);
    logic          intr_q;
    logic [AW-1:0] addr_q;
    logic          viol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            intr_q <= 1'b0;
            addr_q <= '0;
            viol_q <= 1'b0;
        end else begin
            if (enter_prot_i && pf_write_active(ce_n_i, we_n_i)) begin
                intr_q <= 1'b1;
                addr_q <= addr_i;
            end
            if (state_i == PF_RECOVER && !ce_n_i)
                viol_q <= 1'b1;
        end
    end

    assign intr_wr_o   = intr_q;
    assign intr_addr_o = addr_q;
    assign ce_viol_o   = viol_q;

    assert_intr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        $past(intr_q) |-> intr_q);

    assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(state_i) != PF_NORMAL) |-> $stable(addr_q));

    assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        $past(viol_q) |-> viol_q);

    assert_viol_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(viol_q) |-> ($past(state_i) == PF_RECOVER && !$past(ce_n_i)));

endmodule

// File: rtl/pfw_guard.sv
module pfw_guard
    import pfw_pkg::*;
#(
    parameter int AW     = 13,
    parameter int LW     = 8,
    parameter int FILT_N = 4,
    parameter int REC_N  = 125000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          desel_ok_i,
    input  logic          swover_ok_i,
    input  logic          ce_n_i,
    input  logic          we_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic [LW-1:0] lat_i,
    output logic [1:0]    state_o,
    output logic          wprot_o,
    output logic          odis_o,
    output logic          bat_sel_o,
    output logic          intr_wr_o,
    output logic [AW-1:0] intr_addr_o,
    output logic          ce_viol_o
);
    logic [PF_NUM_LVLS-1:0] raw_lvls;
    logic [PF_NUM_LVLS-1:0] flt_lvls;
    pf_levels_t             levels;
    pf_state_e              state;
    logic                   enter_prot;

    assign raw_lvls[PF_LVL_DESEL] = desel_ok_i;
    assign raw_lvls[PF_LVL_SWOVR] = swover_ok_i;

    for (genvar g = 0; g < PF_NUM_LVLS; g++) begin : g_lvl
        pfw_level_filter #(.FILT_N(FILT_N)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw_i (raw_lvls[g]),
            .lvl_o (flt_lvls[g])
        );
    end

    assign levels.above_desel = flt_lvls[PF_LVL_DESEL];
    assign levels.above_swovr = flt_lvls[PF_LVL_SWOVR];

    pfw_seq #(.REC_N(REC_N), .LW(LW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .lv_i         (levels),
        .lat_i        (lat_i),
        .state_o      (state),
        .enter_prot_o (enter_prot)
    );

    pfw_fault_log #(.AW(AW)) u_log (
        .clk          (clk),
        .rst          (rst),
        .state_i      (state),
        .enter_prot_i (enter_prot),
        .ce_n_i       (ce_n_i),
        .we_n_i       (we_n_i),
        .addr_i       (addr_i),
        .intr_wr_o    (intr_wr_o),
        .intr_addr_o  (intr_addr_o),
        .ce_viol_o    (ce_viol_o)
    );

    assign state_o   = state;
    assign wprot_o   = pf_guarded(state);
    assign odis_o    = pf_guarded(state);
    assign bat_sel_o = (state == PF_BATTERY);

    assert_battery_implies_protect_R4: assert property (@(posedge clk) disable iff (rst)
        bat_sel_o |-> (wprot_o && odis_o));

    assert_protect_on_fault_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == PF_NORMAL && !$past(levels.above_swovr)) |-> wprot_o);

endmodule

// File: tb/pfw_guard_tb.sv
module pfw_guard_tb;
    localparam int AW = 4;
    localparam int LW = 4;
    localparam int FILT_N = 3;
    localparam int REC_N = 16;
    localparam int DLY = FILT_N + 3;

    localparam logic [1:0] S_NORM = 2'd0;
    localparam logic [1:0] S_PROT = 2'd1;
    localparam logic [1:0] S_BATT = 2'd2;
    localparam logic [1:0] S_RECV = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic desel_ok = 1'b0;
    logic swover_ok = 1'b0;
    logic ce_n = 1'b1;
    logic we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [LW-1:0] lat = '0;
    logic [1:0] state;
    logic wprot, odis, bat_sel, intr_wr, ce_viol;
    logic [AW-1:0] intr_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pfw_guard #(.AW(AW), .LW(LW), .FILT_N(FILT_N), .REC_N(REC_N)) u_dut (
        .clk(clk), .rst(rst), .desel_ok_i(desel_ok), .swover_ok_i(swover_ok),
        .ce_n_i(ce_n), .we_n_i(we_n), .addr_i(addr), .lat_i(lat),
        .state_o(state), .wprot_o(wprot), .odis_o(odis), .bat_sel_o(bat_sel),
        .intr_wr_o(intr_wr), .intr_addr_o(intr_addr), .ce_viol_o(ce_viol)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_prot(input string req, input int exp_state);
        chk(req, int'(state), exp_state);
        chk(req, int'(wprot), (exp_state != 0) ? 1 : 0);
        chk(req, int'(odis), (exp_state != 0) ? 1 : 0);
        chk(req, int'(bat_sel), (exp_state == 2) ? 1 : 0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        adv(3);
        // R1 reset state
        chk_prot("R1", 1);
        chk("R1 intr", int'(intr_wr), 0);
        chk("R1 addr", int'(intr_addr), 0);
        chk("R1 viol", int'(ce_viol), 0);
        rst = 1'b0;
        adv(1);
        // R4 low switchover while protected -> battery
        chk_prot("R4 battery entry", 2);

        // power returns: R2 delay, R6 battery goes to recover, not normal
        desel_ok = 1'b1; swover_ok = 1'b1;
        adv(DLY - 1);
        chk_prot("R2 before accept", 2);
        adv(1);
        chk_prot("R6 battery to recover", 3);
        adv(REC_N - 1);
        chk_prot("R5 still recovering", 3);
        adv(1);
        chk_prot("R5 normal after count", 0);

        // R9 negative: chip enable in NORMAL
        ce_n = 1'b0; adv(2); ce_n = 1'b1; adv(1);
        chk("R9 no viol in normal", int'(ce_viol), 0);

        // R2 glitch too short, then just long enough
        desel_ok = 1'b0; adv(FILT_N - 1); desel_ok = 1'b1;
        adv(DLY + 4);
        chk_prot("R2 short pulse ignored", 0);
        desel_ok = 1'b0; adv(FILT_N); desel_ok = 1'b1;
        adv(DLY - FILT_N);
        chk_prot("R2 long pulse accepted", 1);
        adv(DLY);
        chk_prot("R2 recover after pulse", 3);
        adv(REC_N);
        chk_prot("R5 normal again", 0);

        // R3 latency 0 with write in flight -> R7 capture
        lat = '0; addr = 4'd5; ce_n = 1'b0; we_n = 1'b0;
        desel_ok = 1'b0;
        adv(DLY - 1);
        chk_prot("R3 lat0 before", 0);
        chk("R7 no flag yet", int'(intr_wr), 0);
        adv(1);
        chk_prot("R3 lat0 protect", 1);
        chk("R7 flag", int'(intr_wr), 1);
        chk("R7 addr", int'(intr_addr), 5);

        // R8 writes while protected are ignored
        addr = 4'd9;
        adv(4);
        ce_n = 1'b1; we_n = 1'b1;
        chk("R8 addr frozen", int'(intr_addr), 5);
        chk_prot("R8 still protected", 1);

        // recovery with a chip-enable violation (R9)
        desel_ok = 1'b1;
        adv(DLY);
        chk_prot("R5 recover entry", 3);
        chk("R9 clear before", int'(ce_viol), 0);
        ce_n = 1'b0; adv(1); ce_n = 1'b1;
        chk("R9 viol set", int'(ce_viol), 1);
        addr = 4'd2;
        adv(REC_N - 2);
        chk_prot("R5 hold", 3);
        chk("R9 viol sticky", int'(ce_viol), 1);
        adv(1);
        chk_prot("R5 release", 0);
        chk("R8 addr after recovery", int'(intr_addr), 5);

        // R5 restart: dip during recovery
        desel_ok = 1'b0; adv(DLY); desel_ok = 1'b1;
        chk_prot("R3 protect", 1);
        adv(DLY);
        chk_prot("R5 recover A", 3);
        adv(2);
        desel_ok = 1'b0;
        adv(DLY);
        chk_prot("R5 dip back to protect", 1);
        desel_ok = 1'b1;
        adv(DLY);
        chk_prot("R5 recover B", 3);
        adv(REC_N - 1);
        chk_prot("R5 full restart hold", 3);
        adv(1);
        chk_prot("R5 full restart release", 0);

        // R3 latency 3, no write in flight
        lat = 4'd3;
        desel_ok = 1'b0;
        adv(DLY + 2);
        chk_prot("R3 lat3 waiting", 0);
        adv(1);
        chk_prot("R3 lat3 protect", 1);
        chk("R7 no new capture", int'(intr_addr), 5);

        // R4 battery while protected, then switchover back with deselect low
        swover_ok = 1'b0;
        adv(DLY);
        chk_prot("R4 battery", 2);
        swover_ok = 1'b1;
        adv(DLY);
        chk_prot("R4 battery released to protect", 1);

        // back to normal
        desel_ok = 1'b1;
        adv(DLY + REC_N);
        chk_prot("R5 normal before bypass test", 0);

        // R4 switchover loss in NORMAL bypasses latency
        lat = 4'd7;
        desel_ok = 1'b0; swover_ok = 1'b0;
        adv(DLY - 1);
        chk_prot("R4 bypass before", 0);
        adv(1);
        chk_prot("R4 bypass protect", 1);
        adv(1);
        chk_prot("R4 then battery", 2);
        adv(5);
        chk_prot("R6 battery holds", 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule